// File: doc/BRIEF.md
# SD Host Transfer Activity Tracker

This block follows the data phase of an SD host controller and reports whether a read or a write transfer is in progress. It takes one-cycle event strobes from the command and data paths: the end bit of a read or write command, a host continue request, a read block handed to the system side, and the CRC status of a written block. It also takes the stop-at-block-gap request as a level, together with a block count and a multi-block flag. From these it keeps three status bits in a 16-bit status word: read active, write active and data line active.

Whenever an activity bit falls, the block sorts the event into one of two classes. A normal end raises a transfer-complete flag. A stop at a block gap raises a block-gap-event flag. Both flags hold their value until the host writes a 1 to clear them. Each flag has its own enable, and the enabled flags are combined into one interrupt line. A remaining-block counter records where the transfer stands, so a transfer paused at a gap resumes with the blocks it still owes.

Top module: `sd_xfer_activity`

## Requirements
- R1: After reset, status_o, int_flag_o and irq_o are all 0. Only bits 9 (read active), 8 (write active) and 2 (data line active) of status_o can ever be 1.
- R2: When no transfer is active, a read command end strobe sets status bits 9 and 2 in the following cycle.
- R3: When no transfer is active, a write command end strobe sets status bits 8 and 2 in the following cycle. If both command strobes arrive in the same cycle, the read strobe wins.
- R4: At command end the remaining-block count loads from blk_cnt_i when multi_blk_i is 1, with a count of 0 taken as 1. It loads 1 when multi_blk_i is 0. Each read block delivered during a read, and each CRC status received during a write, lowers the count by one. The transfer ends on the block that brings the count to zero.
- R5: When the last read block is delivered, bits 9 and 2 clear in the next cycle and the transfer-complete flag (int_flag_o bit 0) sets. The block-gap flag is not set.
- R6: A read block that is not the last, delivered while stop_gap_i is 1, clears bits 9 and 2 and sets both the transfer-complete flag and the block-gap flag (int_flag_o bit 1).
- R7: When the CRC status of the last written block arrives, bits 8 and 2 clear and the transfer-complete flag sets. The block-gap flag is not set.
- R8: A CRC status for a block that is not the last, received while stop_gap_i is 1, clears bits 8 and 2 and sets the block-gap flag only.
- R9: A continue request while paused at a gap resumes in the paused direction, and the remaining count carries on from where it stopped. A continue request when nothing is paused has no effect.
- R10: Read block strobes outside a read and CRC strobes outside a write are ignored. Command end strobes during an active transfer are ignored.
- R11: The flags stay set until int_clr_i is 1 in the matching bit (bit 0 transfer complete, bit 1 block gap). If a flag is set and cleared in the same cycle, the set wins.
- R12: irq_o is 1 exactly when some flag is set and its bit in int_en_i is 1. irq_o follows int_en_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_cmd_end_i | input | 1 | End bit of a read command seen |
| wr_cmd_end_i | input | 1 | End bit of a write command seen |
| cont_req_i | input | 1 | Host wrote 1 to continue request |
| rd_blk_done_i | input | 1 | One read block delivered to the system side |
| wr_crc_stat_i | input | 1 | CRC status of one written block received |
| stop_gap_i | input | 1 | Stop-at-block-gap request level |
| multi_blk_i | input | 1 | 1 = multi-block transfer, 0 = single block |
| blk_cnt_i | input | CNT_W | Programmed block count |
| int_clr_i | input | 2 | Write-1-to-clear strobes for the flags |
| int_en_i | input | 2 | Per-flag interrupt enables |
| status_o | output | 16 | Status word (bits 9, 8, 2 used) |
| int_flag_o | output | 2 | Sticky flags: bit 0 transfer complete, bit 1 block gap |
| irq_o | output | 1 | Combined enabled interrupt |

## Verification
If the remaining-block count is wrong, a transfer ends one block too early or too late. That shows as status bit 9 or 8 falling on the wrong strobe, so it is visible one cycle after the block in question. If a gap stop is misclassified, it sets the wrong flag in that same cycle. If the paused direction is lost, status_o reports the wrong active bit one cycle after the continue request. If the count is lost across a pause, the error shows only when the resumed transfer ends at the wrong block.

// File: rtl/sd_xfer_pkg.sv
package sd_xfer_pkg;
    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_READ  = 2'd1,
        XS_WRITE = 2'd2,
        XS_GAP   = 2'd3
    } xfer_st_e;

    localparam int STAT_W  = 16;
    localparam int RD_BIT  = 9;
    localparam int WR_BIT  = 8;
    localparam int DAT_BIT = 2;
    localparam int IRQ_N   = 2;
    localparam int IRQ_TC  = 0;
    localparam int IRQ_BGE = 1;

    typedef struct packed {
        logic rd_cmd;
        logic wr_cmd;
        logic cont;
        logic rd_blk;
        logic wr_crc;
        logic stop;
    } xfer_evt_t;
endpackage

// File: rtl/sd_xfer_blkcnt.sv
module sd_xfer_blkcnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          multi_i,
    input  logic          dec_i,
    output logic [CW-1:0] rem_o,
    output logic          last_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] rem;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            if (!multi_i || load_val_i == '0) cnt_d.rem = ONE;
            else                              cnt_d.rem = load_val_i;
        end else if (dec_i && cnt_q.rem != '0) begin
            cnt_d.rem = cnt_q.rem - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign rem_o  = cnt_q.rem;
    assign last_o = (cnt_q.rem == ONE);

    // R4: a block is only ever counted while blocks remain
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> cnt_q.rem != '0);
    // R4: a counted block lowers the count by exactly one
    p_dec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |=> cnt_q.rem == $past(cnt_q.rem) - ONE);
endmodule

// File: rtl/sd_xfer_ctrl.sv
module sd_xfer_ctrl
    import sd_xfer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  xfer_evt_t evt_i,
    input  logic      last_i,
    output logic      load_o,
    output logic      dec_o,
    output xfer_st_e  st_o,
    output logic      tc_evt_o,
    output logic      bge_evt_o
);
    typedef struct packed {
        xfer_st_e st;
        logic     dir_wr;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;
    logic  load_d, dec_d, tc_d, bge_d;

    always_comb begin
        ctl_d  = ctl_q;
        load_d = 1'b0;
        dec_d  = 1'b0;
        tc_d   = 1'b0;
        bge_d  = 1'b0;
        unique case (ctl_q.st)
            XS_IDLE, XS_GAP: begin
                if (evt_i.rd_cmd) begin
                    ctl_d.st     = XS_READ;
                    ctl_d.dir_wr = 1'b0;
                    load_d       = 1'b1;
                end else if (evt_i.wr_cmd) begin
                    ctl_d.st     = XS_WRITE;
                    ctl_d.dir_wr = 1'b1;
                    load_d       = 1'b1;
                end else if (ctl_q.st == XS_GAP && evt_i.cont) begin
                    ctl_d.st = ctl_q.dir_wr ? XS_WRITE : XS_READ;
                end
            end
            XS_READ: begin
                if (evt_i.rd_blk) begin
                    dec_d = 1'b1;
                    if (last_i) begin
                        ctl_d.st = XS_IDLE;
                        tc_d     = 1'b1;
                    end else if (evt_i.stop) begin
                        ctl_d.st = XS_GAP;
                        tc_d     = 1'b1;
                        bge_d    = 1'b1;
                    end
                end
            end
            XS_WRITE: begin
                if (evt_i.wr_crc) begin
                    dec_d = 1'b1;
                    if (last_i) begin
                        ctl_d.st = XS_IDLE;
                        tc_d     = 1'b1;
                    end else if (evt_i.stop) begin
                        ctl_d.st = XS_GAP;
                        bge_d    = 1'b1;
                    end
                end
            end
            default: ctl_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: XS_IDLE, dir_wr: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign load_o    = load_d;
    assign dec_o     = dec_d;
    assign st_o      = ctl_q.st;
    assign tc_evt_o  = tc_d;
    assign bge_evt_o = bge_d;

    // R10: a command end during an active transfer leaves the state alone
    p_cmd_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == XS_READ && !evt_i.rd_blk) |=> ctl_q.st == XS_READ);
    // R9: a resume goes back to the paused direction
    p_resume_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == XS_GAP && evt_i.cont && !evt_i.rd_cmd && !evt_i.wr_cmd)
        |=> ctl_q.st == (ctl_q.dir_wr ? XS_WRITE : XS_READ));
endmodule

// File: rtl/sd_xfer_irq.sv
module sd_xfer_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] flag_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } irq_s;

    irq_s irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        for (int i = 0; i < N; i++) begin
            if (set_i[i])      irq_d.flag[i] = 1'b1;
            else if (clr_i[i]) irq_d.flag[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign flag_o = irq_q.flag;
    assign irq_o  = |(irq_q.flag & en_i);

    generate
        for (genvar g = 0; g < N; g++) begin : g_chk
            // R11: a set flag stays set unless cleared
            p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_q.flag[g] && !clr_i[g]) |=> irq_q.flag[g]);
            // R11: a clear with no event in the same cycle drops the flag
            p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[g] && !set_i[g]) |=> !irq_q.flag[g]);
        end
    endgenerate
endmodule

// File: rtl/sd_xfer_activity.sv
module sd_xfer_activity
    import sd_xfer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cmd_end_i,
    input  logic              wr_cmd_end_i,
    input  logic              cont_req_i,
    input  logic              rd_blk_done_i,
    input  logic              wr_crc_stat_i,
    input  logic              stop_gap_i,
    input  logic              multi_blk_i,
    input  logic [CNT_W-1:0]  blk_cnt_i,
    input  logic [IRQ_N-1:0]  int_clr_i,
    input  logic [IRQ_N-1:0]  int_en_i,
    output logic [STAT_W-1:0] status_o,
    output logic [IRQ_N-1:0]  int_flag_o,
    output logic              irq_o
);
    xfer_evt_t      evt;
    xfer_st_e       st;
    logic           load, dec, last, tc_evt, bge_evt;
    logic [CNT_W-1:0] rem;
    logic [IRQ_N-1:0] irq_set;

    assign evt = '{rd_cmd: rd_cmd_end_i, wr_cmd: wr_cmd_end_i, cont: cont_req_i,
                   rd_blk: rd_blk_done_i, wr_crc: wr_crc_stat_i, stop: stop_gap_i};

    sd_xfer_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .last_i    (last),
        .load_o    (load),
        .dec_o     (dec),
        .st_o      (st),
        .tc_evt_o  (tc_evt),
        .bge_evt_o (bge_evt)
    );

    sd_xfer_blkcnt #(.CW(CNT_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (blk_cnt_i),
        .multi_i    (multi_blk_i),
        .dec_i      (dec),
        .rem_o      (rem),
        .last_o     (last)
    );

    always_comb begin
        irq_set          = '0;
        irq_set[IRQ_TC]  = tc_evt;
        irq_set[IRQ_BGE] = bge_evt;
    end

    sd_xfer_irq #(.N(IRQ_N)) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_set),
        .clr_i  (int_clr_i),
        .en_i   (int_en_i),
        .flag_o (int_flag_o),
        .irq_o  (irq_o)
    );

    always_comb begin
        status_o          = '0;
        status_o[RD_BIT]  = (st == XS_READ);
        status_o[WR_BIT]  = (st == XS_WRITE);
        status_o[DAT_BIT] = (st == XS_READ) || (st == XS_WRITE);
    end

    // R5: read active falling always leaves transfer complete flagged
    p_rd_fall_tc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[RD_BIT]) |-> int_flag_o[IRQ_TC]);
    // R8: write stop at a gap flags the block gap event
    p_wr_gap_bge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[WR_BIT] && wr_crc_stat_i && stop_gap_i && rem != CNT_W'(1))
        |=> int_flag_o[IRQ_BGE] && !status_o[WR_BIT]);
    // R4: an active transfer always owes at least one block
    p_rem_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[DAT_BIT] |-> rem != '0);
    // R2: a read command end when idle starts a read
    p_rd_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[DAT_BIT] && rd_cmd_end_i) |=> status_o[RD_BIT] && status_o[DAT_BIT]);
endmodule

// File: tb/test_sd_xfer_activity.sv
module test_sd_xfer_activity;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_cmd_end_i = 0, wr_cmd_end_i = 0, cont_req_i = 0;
    logic        rd_blk_done_i = 0, wr_crc_stat_i = 0, stop_gap_i = 0, multi_blk_i = 0;
    logic [15:0] blk_cnt_i = '0;
    logic [1:0]  int_clr_i = '0, int_en_i = '0;
    logic [15:0] status_o;
    logic [1:0]  int_flag_o;
    logic        irq_o;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    sd_xfer_activity i_sd_xfer_activity (.*);

    localparam logic [15:0] S_RD = 16'h0204, S_WR = 16'h0104, S_ID = 16'h0000;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one-cycle strobe; returns at the negedge after the capturing edge
    task automatic strobe(input logic rc, input logic wc, input logic ct,
                          input logic rb, input logic crc, input logic [1:0] clr);
        @(negedge clk);
        rd_cmd_end_i = rc; wr_cmd_end_i = wc; cont_req_i = ct;
        rd_blk_done_i = rb; wr_crc_stat_i = crc; int_clr_i = clr;
        @(negedge clk);
        rd_cmd_end_i = 0; wr_cmd_end_i = 0; cont_req_i = 0;
        rd_blk_done_i = 0; wr_crc_stat_i = 0; int_clr_i = '0;
    endtask

    task automatic clear_all();
        strobe(0, 0, 0, 0, 0, 2'b11);
        chk("R11 clear both", {30'd0, int_flag_o}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 status", {16'd0, status_o}, 32'd0);
        chk("R1 flags", {30'd0, int_flag_o}, 32'd0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_read_multi();
        multi_blk_i = 1; blk_cnt_i = 16'd3;
        strobe(1, 0, 0, 0, 0, 2'b00);
        chk("R2 read active", {16'd0, status_o}, {16'd0, S_RD});
        strobe(0, 0, 0, 1, 0, 2'b00);
        strobe(0, 0, 0, 1, 0, 2'b00);
        chk("R4 two of three blocks", {16'd0, status_o}, {16'd0, S_RD});
        strobe(0, 0, 0, 0, 1, 2'b00);
        chk("R10 crc in read ignored", {16'd0, status_o}, {16'd0, S_RD});
        strobe(0, 0, 0, 1, 0, 2'b00);
        chk("R5 read done status", {16'd0, status_o}, {16'd0, S_ID});
        chk("R5 tc only", {30'd0, int_flag_o}, 32'd1);
        chk("R12 irq disabled", {31'd0, irq_o}, 32'd0);
        int_en_i = 2'b01; #1;
        chk("R12 irq tc enabled", {31'd0, irq_o}, 32'd1);
        int_en_i = 2'b10; #1;
        chk("R12 irq other enable", {31'd0, irq_o}, 32'd0);
        int_en_i = 2'b00;
        strobe(0, 0, 0, 0, 0, 2'b00);
        chk("R11 sticky", {30'd0, int_flag_o}, 32'd1);
        clear_all();
    endtask

    task automatic t_write_single();
        multi_blk_i = 0; blk_cnt_i = 16'd5;
        strobe(0, 1, 0, 0, 0, 2'b00);
        chk("R3 write active", {16'd0, status_o}, {16'd0, S_WR});
        strobe(0, 0, 0, 1, 0, 2'b00);
        chk("R10 read blk in write ignored", {16'd0, status_o}, {16'd0, S_WR});
        strobe(0, 0, 0, 0, 1, 2'b00);
        chk("R7 single write done", {16'd0, status_o}, {16'd0, S_ID});
        chk("R7 tc only", {30'd0, int_flag_o}, 32'd1);
        clear_all();
    endtask

    task automatic t_write_gap();
        multi_blk_i = 1; blk_cnt_i = 16'd3;
        strobe(0, 1, 0, 0, 0, 2'b00);
        stop_gap_i = 1;
        strobe(0, 0, 0, 0, 1, 2'b00);
        chk("R8 write gap status", {16'd0, status_o}, {16'd0, S_ID});
        chk("R8 bge only", {30'd0, int_flag_o}, 32'd2);
        int_en_i = 2'b10; #1;
        chk("R12 irq bge", {31'd0, irq_o}, 32'd1);
        int_en_i = 2'b00;
        stop_gap_i = 0;
        strobe(0, 0, 1, 0, 0, 2'b00);
        chk("R9 resume write", {16'd0, status_o}, {16'd0, S_WR});
        strobe(0, 0, 0, 0, 1, 2'b00);
        chk("R9 count kept", {16'd0, status_o}, {16'd0, S_WR});
        strobe(0, 0, 0, 0, 1, 2'b00);
        chk("R4 resumed write done", {16'd0, status_o}, {16'd0, S_ID});
        chk("R7 tc after resume", {30'd0, int_flag_o}, 32'd3);
        clear_all();
    endtask

    task automatic t_read_gap();
        multi_blk_i = 1; blk_cnt_i = 16'd2;
        strobe(1, 0, 0, 0, 0, 2'b00);
        stop_gap_i = 1;
        strobe(0, 0, 0, 1, 0, 2'b00);
        stop_gap_i = 0;
        chk("R6 read gap status", {16'd0, status_o}, {16'd0, S_ID});
        chk("R6 tc and bge", {30'd0, int_flag_o}, 32'd3);
        clear_all();
        strobe(0, 0, 1, 0, 0, 2'b00);
        chk("R9 resume read", {16'd0, status_o}, {16'd0, S_RD});
        strobe(0, 0, 0, 1, 0, 2'b00);
        chk("R5 resumed read done", {16'd0, status_o}, {16'd0, S_ID});
        chk("R5 tc after resume", {30'd0, int_flag_o}, 32'd1);
        clear_all();
    endtask

    task automatic t_ignore();
        strobe(0, 0, 1, 0, 0, 2'b00);
        chk("R9 continue when idle", {16'd0, status_o}, {16'd0, S_ID});
        strobe(0, 0, 0, 1, 1, 2'b00);
        chk("R10 strobes when idle", {30'd0, int_flag_o}, 32'd0);
        multi_blk_i = 1; blk_cnt_i = 16'd2;
        strobe(1, 1, 0, 0, 0, 2'b00);
        chk("R3 read wins tie", {16'd0, status_o}, {16'd0, S_RD});
        strobe(0, 1, 0, 0, 0, 2'b00);
        chk("R10 cmd end during read", {16'd0, status_o}, {16'd0, S_RD});
        strobe(0, 0, 0, 1, 0, 2'b00);
        chk("R10 count not reloaded", {16'd0, status_o}, {16'd0, S_RD});
        strobe(0, 0, 0, 1, 0, 2'b00);
        chk("R4 two blocks done", {16'd0, status_o}, {16'd0, S_ID});
        clear_all();
    endtask

    task automatic t_zero_and_setwins();
        multi_blk_i = 1; blk_cnt_i = 16'd0;
        strobe(1, 0, 0, 0, 0, 2'b00);
        strobe(0, 0, 0, 1, 2'b01 == 2'b00, 2'b01);
        chk("R4 zero count is one", {16'd0, status_o}, {16'd0, S_ID});
        chk("R11 set wins over clear", {30'd0, int_flag_o}, 32'd1);
        clear_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read_multi();
        t_write_single();
        t_write_gap();
        t_read_gap();
        t_ignore();
        t_zero_and_setwins();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule